// File: doc/BRIEF.md
# PLL Enable and Lock Sequencer

This block sits between the control registers of one phase-locked loop and its analog core. It drives the core's effective integer multiplier, fractional numerator and fractional denominator, and reports three status flags: on, busy and ready. The output frequency is the reference frequency times (multiplier + numerator/denominator). All time is counted in reference clock cycles.

When the enable request rises, the sequencer samples the denominator, loads the clamped multiplier and waits out a programmable lock time before it raises ready. A slow-lock option stretches that wait to four times the programmed count. If the multiplier setting changes while the loop runs, the sequencer walks the effective multiplier toward the new value one unit at a time, with a programmable dwell at each step, and holds busy high until it arrives. The numerator passes straight through, so it can be retuned at any time. The denominator takes effect only at the next enable.

The controller has four states:
- `ST_OFF`: idle. The multiplier sits at 16.
- `ST_LOCK`: waiting for lock.
- `ST_RUN`: stable.
- `ST_STEP`: walking the multiplier.

Its transitions are:
- **power-up**: `ST_OFF`→`ST_LOCK`, when the enable request is seen.
- **lock-done**: `ST_LOCK`→`ST_RUN`, when the lock counter reaches zero.
- **retune**: `ST_RUN`→`ST_STEP`, when the clamped target differs from the effective multiplier.
- **step-again**: `ST_STEP`→`ST_STEP`, when the dwell expires and the target is not yet reached.
- **arrive**: `ST_STEP`→`ST_RUN`, when the dwell expires and the multiplier equals the target.
- **shutdown**: any state →`ST_OFF`, when the enable request is low.

Top module: `pll_seq`

## Requirements
- R1: After reset the outputs are as follows: on, busy, ready and the error flag are 0, the effective multiplier is 16, and the effective denominator is 0.
- R2: On the clock edge that samples a high enable request in the off state, on and busy become 1, ready stays 0, and the effective multiplier takes the clamped multiplier setting.
- R3: With slow-lock clear and lock count L, ready rises and busy falls on the (L+1)-th clock edge after the edge that sampled the enable.
- R4: With slow-lock set, the same rise happens on the (4L+1)-th edge after the enabling edge.
- R5: One edge after the enable request is sampled low, on, busy and ready are 0 and the effective multiplier is 16. This holds from any state.
- R6: The effective numerator always equals the numerator setting in the same cycle, whether the loop is on or off.
- R7: The effective denominator is captured from the setting only on the enabling edge. Changes to the setting while the loop is on do not reach the output until the next enable.
- R8: While running, a new multiplier setting makes the effective multiplier move by exactly one toward it on the next edge. Each further one-unit move follows after D+1 edges, where D is the step time. Ready returns D+1 edges after the final move. Busy is 1 and ready is 0 throughout the walk.
- R9: A multiplier setting below 16 is treated as 16, and a setting above 42 is treated as 42.
- R10: A multiplier setting outside 16..42 sets the error flag on the next edge. The flag then stays set until reset.
- R11: While on, the effective multiplier stays in 16..42 and never changes by more than one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_req | input | 1 | Enable request for the loop |
| mult_cfg | input | 7 | Integer multiplier setting |
| num_cfg | input | 30 | Fractional numerator setting |
| den_cfg | input | 30 | Fractional denominator setting |
| lock_cycles | input | 16 | Lock wait in reference cycles |
| dwell_cycles | input | 16 | Dwell per multiplier step in reference cycles |
| slow_lock | input | 1 | 1 = lock wait is four times the lock count |
| mult_eff | output | 7 | Multiplier applied to the loop |
| num_eff | output | 30 | Numerator applied to the loop |
| den_eff | output | 30 | Denominator applied to the loop |
| on_o | output | 1 | Loop is powered |
| busy_o | output | 1 | Loop is locking or retuning |
| ready_o | output | 1 | Loop is stable for use |
| mult_err | output | 1 | Sticky flag for an out-of-range multiplier setting |

## Verification
The hardest case to reach from the ports is a multi-step retune. Seeing it means letting the loop lock first, then changing the multiplier by several units, and sampling the effective multiplier inside each dwell window and at each step boundary. The bench keeps the lock and dwell counts small, so every step edge falls at a cycle it computes in advance. It walks upward and then downward, and it also drops the enable partway through a lock wait.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    localparam int MULT_W     = 7;
    localparam int FRAC_W     = 30;
    localparam int TIME_W     = 16;
    localparam int SLOW_SHIFT = 2;
    localparam int CNT_W      = TIME_W + SLOW_SHIFT;
    localparam int MULT_MIN   = 16;
    localparam int MULT_MAX   = 42;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOCK = 2'd1,
        ST_RUN  = 2'd2,
        ST_STEP = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pll_seq_clamp.sv
module pll_seq_clamp #(
    parameter int W    = 7,
    parameter int LO   = 16,
    parameter int HI   = 42
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] clamped,
    output logic         invalid
);
    localparam logic [W-1:0] LO_V = W'(LO);
    localparam logic [W-1:0] HI_V = W'(HI);

    always_comb begin
        if (raw < LO_V) begin
            clamped = LO_V;
            invalid = 1'b1;
        end else if (raw > HI_V) begin
            clamped = HI_V;
            invalid = 1'b1;
        end else begin
            clamped = raw;
            invalid = 1'b0;
        end
    end
endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // The counter never wraps upward except by an explicit load.
    assert_timer_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt) != '0) |-> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pll_seq.sv
module pll_seq
    import pll_seq_pkg::*;
#(
    parameter int MW = MULT_W,
    parameter int FW = FRAC_W,
    parameter int TW = TIME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_req,
    input  logic [MW-1:0] mult_cfg,
    input  logic [FW-1:0] num_cfg,
    input  logic [FW-1:0] den_cfg,
    input  logic [TW-1:0] lock_cycles,
    input  logic [TW-1:0] dwell_cycles,
    input  logic          slow_lock,
    output logic [MW-1:0] mult_eff,
    output logic [FW-1:0] num_eff,
    output logic [FW-1:0] den_eff,
    output logic          on_o,
    output logic          busy_o,
    output logic          ready_o,
    output logic          mult_err
);
    localparam int CW = TW + SLOW_SHIFT;
    localparam logic [MW-1:0] IDLE_MULT = MW'(MULT_MIN);
    localparam logic [MW-1:0] TOP_MULT  = MW'(MULT_MAX);

    seq_state_t    state, state_nx;
    logic [MW-1:0] target;
    logic          bad_cfg;
    logic          tmr_load, tmr_done;
    logic [CW-1:0] tmr_val, lock_limit;
    logic [MW-1:0] mult_nx;
    logic          den_take;

    pll_seq_clamp #(.W(MW), .LO(MULT_MIN), .HI(MULT_MAX)) u_clamp (
        .raw     (mult_cfg),
        .clamped (target),
        .invalid (bad_cfg)
    );

    pll_seq_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    assign lock_limit = slow_lock ? {lock_cycles, {SLOW_SHIFT{1'b0}}}
                                  : {{SLOW_SHIFT{1'b0}}, lock_cycles};

    // Next state, timer control and multiplier update.
    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        mult_nx  = mult_eff;
        den_take = 1'b0;
        if (!en_req) begin
            state_nx = ST_OFF;
            mult_nx  = IDLE_MULT;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_nx = ST_LOCK;
                    tmr_load = 1'b1;
                    tmr_val  = lock_limit;
                    mult_nx  = target;
                    den_take = 1'b1;
                end
                ST_LOCK: begin
                    if (tmr_done) state_nx = ST_RUN;
                end
                ST_RUN: begin
                    if (target != mult_eff) begin
                        state_nx = ST_STEP;
                        tmr_load = 1'b1;
                        tmr_val  = CW'(dwell_cycles);
                        mult_nx  = (target > mult_eff) ? mult_eff + 1'b1 : mult_eff - 1'b1;
                    end
                end
                ST_STEP: begin
                    if (tmr_done) begin
                        if (target == mult_eff) begin
                            state_nx = ST_RUN;
                        end else begin
                            tmr_load = 1'b1;
                            tmr_val  = CW'(dwell_cycles);
                            mult_nx  = (target > mult_eff) ? mult_eff + 1'b1 : mult_eff - 1'b1;
                        end
                    end
                end
                default: state_nx = ST_OFF;
            endcase
        end
    end

    // State register and datapath registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_OFF;
            mult_eff <= IDLE_MULT;
            den_eff  <= '0;
            mult_err <= 1'b0;
        end else begin
            state    <= state_nx;
            mult_eff <= mult_nx;
            if (den_take) den_eff <= den_cfg;
            if (bad_cfg)  mult_err <= 1'b1;
        end
    end

    // Status outputs decoded from the state.
    always_comb begin
        on_o    = 1'b0;
        busy_o  = 1'b0;
        ready_o = 1'b0;
        unique case (state)
            ST_OFF:  ;
            ST_LOCK: begin on_o = 1'b1; busy_o = 1'b1; end
            ST_RUN:  begin on_o = 1'b1; ready_o = 1'b1; end
            ST_STEP: begin on_o = 1'b1; busy_o = 1'b1; end
            default: ;
        endcase
    end

    assign num_eff = num_cfg;

    assert_busy_ready_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && ready_o));

    assert_shutdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_req |=> (!on_o && !busy_o && !ready_o && mult_eff == IDLE_MULT));

    assert_mult_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        on_o |-> (mult_eff >= IDLE_MULT && mult_eff <= TOP_MULT));

    assert_unit_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(on_o) && on_o) |->
            (mult_eff == $past(mult_eff) || mult_eff == $past(mult_eff) + 1'b1 ||
             mult_eff == $past(mult_eff) - 1'b1));

    assert_den_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(on_o) && on_o) |-> $stable(den_eff));

    assert_ready_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(busy_o));

    assert_err_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cfg |=> mult_err);

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mult_err) |-> mult_err);
endmodule

// File: tb/pll_seq_test.sv
module pll_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en_req = 1'b0;
    logic [6:0]  mult_cfg = 7'd20;
    logic [29:0] num_cfg = '0;
    logic [29:0] den_cfg = '0;
    logic [15:0] lock_cycles = '0;
    logic [15:0] dwell_cycles = '0;
    logic        slow_lock = 1'b0;
    logic [6:0]  mult_eff;
    logic [29:0] num_eff, den_eff;
    logic        on_o, busy_o, ready_o, mult_err;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pll_seq uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .mult_cfg(mult_cfg),
        .num_cfg(num_cfg), .den_cfg(den_cfg), .lock_cycles(lock_cycles),
        .dwell_cycles(dwell_cycles), .slow_lock(slow_lock), .mult_eff(mult_eff),
        .num_eff(num_eff), .den_eff(den_eff), .on_o(on_o), .busy_o(busy_o),
        .ready_o(ready_o), .mult_err(mult_err)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Fields per entry: {mult_cfg[6:0], lock[15:0], slow, expected mult_eff[6:0]}.
    localparam int NV = 6;
    localparam logic [30:0] VEC [0:NV-1] = '{
        {7'd20,  16'd5, 1'b0, 7'd20},
        {7'd16,  16'd0, 1'b0, 7'd16},
        {7'd42,  16'd3, 1'b1, 7'd42},
        {7'd10,  16'd2, 1'b0, 7'd16},
        {7'd100, 16'd1, 1'b1, 7'd42},
        {7'd30,  16'd7, 1'b0, 7'd30}
    };

    initial begin
        #2_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        edges(2);
        rst_n = 1'b1;
        edges(1);
        // R1: reset state
        check("R1 on", on_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 ready", ready_o, 0);
        check("R1 err", mult_err, 0);
        check("R1 mult", mult_eff, 16);
        check("R1 den", den_eff, 0);

        // Table walk: lock timing in fast (R3) and slow (R4) modes, clamp (R9).
        for (int v = 0; v < NV; v++) begin
            int lk, exp_edges, cnt;
            mult_cfg  = VEC[v][30:24];
            lock_cycles = VEC[v][23:8];
            slow_lock = VEC[v][7];
            lk = int'(VEC[v][23:8]);
            exp_edges = (VEC[v][7] ? 4 * lk : lk) + 2;
            en_req = 1'b1;
            edges(1);
            check("R2 on", on_o, 1);
            check("R2 busy", busy_o, (exp_edges == 1) ? 0 : 1);
            check("R9 mult clamp", mult_eff, VEC[v][6:0]);
            cnt = 1;
            while (!ready_o && cnt < 1000) begin
                edges(1);
                cnt++;
            end
            check(VEC[v][7] ? "R4 slow lock edges" : "R3 lock edges", cnt, exp_edges);
            check("R3 busy low at ready", busy_o, 0);
            en_req = 1'b0;
            edges(2);
        end
        // R10: invalid entries in the table leave the flag set
        check("R10 sticky err", mult_err, 1);

        rst_n = 1'b0;
        edges(1);
        rst_n = 1'b1;
        edges(1);
        check("R10 cleared by reset", mult_err, 0);
        mult_cfg = 7'd43;
        edges(1);
        check("R10 err next edge", mult_err, 1);
        mult_cfg = 7'd25;
        edges(3);
        check("R10 err holds", mult_err, 1);

        // R7: denominator capture
        den_cfg = 30'd1000;
        lock_cycles = 16'd2;
        slow_lock = 1'b0;
        mult_cfg = 7'd20;
        en_req = 1'b1;
        edges(1);
        check("R7 den captured", den_eff, 1000);
        den_cfg = 30'd777;
        edges(5);
        check("R7 den ignored while on", den_eff, 1000);
        // R6: numerator passthrough
        num_cfg = 30'd12345;
        #1;
        check("R6 num immediate", num_eff, 12345);
        // R8: upward walk 20 -> 23, dwell 3
        dwell_cycles = 16'd3;
        check("R8 ready before walk", ready_o, 1);
        mult_cfg = 7'd23;
        edges(1);
        check("R8 first step", mult_eff, 21);
        check("R8 busy", busy_o, 1);
        edges(3);
        check("R8 dwell hold", mult_eff, 21);
        check("R8 ready low", ready_o, 0);
        edges(1);
        check("R8 second step", mult_eff, 22);
        edges(4);
        check("R8 third step", mult_eff, 23);
        edges(3);
        check("R8 still busy", busy_o, 1);
        edges(1);
        check("R8 ready back", ready_o, 1);
        // R8: downward walk 23 -> 21
        mult_cfg = 7'd21;
        edges(1);
        check("R8 down step", mult_eff, 22);
        edges(4);
        check("R8 down step2", mult_eff, 21);
        edges(4);
        check("R8 down ready", ready_o, 1);
        // R5: disable while running
        num_cfg = 30'd5;
        en_req = 1'b0;
        edges(1);
        check("R5 on", on_o, 0);
        check("R5 ready", ready_o, 0);
        check("R5 mult idle", mult_eff, 16);
        check("R6 num while off", num_eff, 5);
        // R7: next enable takes the new denominator
        lock_cycles = 16'd50;
        en_req = 1'b1;
        edges(1);
        check("R7 den on re-enable", den_eff, 777);
        edges(10);
        // R5: disable partway through lock wait
        en_req = 1'b0;
        edges(1);
        check("R5 busy mid lock", busy_o, 0);
        check("R5 on mid lock", on_o, 0);
        check("R5 mult mid lock", mult_eff, 16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule